// File: doc/BRIEF.md
# Multi-Source Reset Controller

The controller merges eight reset requests into one synchronous system reset. Two of them are levels: power-on and brown-out. The external pin is also a level, but it must pass a glitch filter first. The other five are single-cycle pulses: software reset instruction, watchdog timeout, trap conflict, illegal opcode and uninitialized working-register access. A stretch counter keeps the system reset asserted for a fixed hold time after the last request has gone away.

A sticky reset-cause register records which sources have fired. Firmware can overwrite the register through a simple write port without causing a reset. Power-on reloads the register to a fixed pattern. Every other source only adds its own bit, so causes pile up until software clears them.

Top module: `rst_hub`

## Requirements
- R1: Any active request asserts `sys_rst_o` at the first rising clock edge that samples it. The requests are `por_i`, `bor_i`, any of the five pulse inputs, or the filtered external pin.
- R2: A merged request seen on r consecutive rising edges keeps `sys_rst_o` high for exactly r + HOLD_CYC − 1 cycles, which is r + 15 with defaults. `sys_rst_o` falls synchronously HOLD_CYC edges after the last edge that sampled a request.
- R3: The pin input `ext_rst_n_i` is active low. It yields a request only once it has been sampled low on FILT_LEN (4) consecutive edges. A low run of L ≥ 4 edges yields L − 3 request edges. A shorter run changes neither `sys_rst_o` nor `cause_o[6]`.
- R4: The `cause_o` bit positions are: 0 power-on, 1 brown-out, 2 uninitialized W register, 3 illegal opcode, 4 watchdog, 5 software reset, 6 external pin, 7 trap conflict. Each event sets its own bit at the same edge that asserts `sys_rst_o`.
- R5: On every edge that samples `por_i` high, `cause_o` becomes 8'h03 and `sys_rst_o` is asserted. This holds whatever else is requested or written in that cycle.
- R6: Outside power-on, with no write, bits of `cause_o` are never cleared, so several causes accumulate.
- R7: When `wr_en_i` is sampled high, `cause_o` takes `wr_data_i` at that edge. A write never asserts `sys_rst_o`.
- R8: If a write and a hardware event hit the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on request, level, also clears the block |
| bor_i | input | 1 | Brown-out request, level |
| ext_rst_n_i | input | 1 | External reset pin, active low, unfiltered |
| swr_i | input | 1 | Software reset instruction, one-cycle pulse |
| wdt_i | input | 1 | Watchdog timeout, one-cycle pulse |
| trap_i | input | 1 | Trap conflict, one-cycle pulse |
| illop_i | input | 1 | Illegal opcode, one-cycle pulse |
| uninitw_i | input | 1 | Uninitialized working-register access, one-cycle pulse |
| wr_en_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 8 | Cause register write value |
| cause_o | output | 8 | Reset-cause register |
| sys_rst_o | output | 1 | Combined, stretched system reset |

## Verification
Several properties are checked every cycle. Any request is followed by reset on the next edge. A fall of reset is always preceded by exactly HOLD_CYC quiet cycles, which the checker counts. Cause bits never drop without a write. A write lands unless hardware sets the same bit, and a clean write never raises reset. A rising pin cause bit must follow at least FILT_LEN low samples. Only the bench's sweeps show exact durations against the r + 15 formula: the length of reset for every glitch length from 1 to 6, the full 256-value write sweep, and the exact single-bit cause pattern of each source in isolation.

// File: rtl/rst_hub_pkg.sv
`timescale 1ns/1ps
package rst_hub_pkg;
    localparam int CAUSE_W   = 8;
    localparam int B_POR     = 0;
    localparam int B_BOR     = 1;
    localparam int B_UNINITW = 2;
    localparam int B_ILLOP   = 3;
    localparam int B_WDT     = 4;
    localparam int B_SWR     = 5;
    localparam int B_PIN     = 6;
    localparam int B_TRAP    = 7;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t POR_VALUE = cause_t'((1 << B_POR) | (1 << B_BOR));
endpackage

// File: rtl/rst_hub_pinfilt.sv
`timescale 1ns/1ps
module rst_hub_pinfilt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic pin_n_i,
    output logic req_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    typedef struct packed {
        logic [CW-1:0] run;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || pin_n_i) begin
            st_d.run = '0;
        end else if (st_q.run != FULL) begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign req_o = (st_q.run == FULL);
endmodule

// File: rtl/rst_hub_stretch.sv
`timescale 1ns/1ps
module rst_hub_stretch #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk_i,
    input  logic req_i,
    output logic rst_o
);
    localparam int HW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          active;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign rst_o = st_q.active;
endmodule

// File: rtl/rst_hub_cause.sv
`timescale 1ns/1ps
module rst_hub_cause
    import rst_hub_pkg::*;
(
    input  logic   clk_i,
    input  logic   por_i,
    input  cause_t evt_i,
    input  logic   wr_en_i,
    input  cause_t wr_data_i,
    output cause_t cause_o
);
    typedef struct packed {
        cause_t bits;
    } cause_st_t;

    cause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.bits = wr_data_i;
        end
        st_d.bits = st_d.bits | evt_i;
        if (por_i) begin
            st_d.bits = POR_VALUE;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cause_o = st_q.bits;
endmodule

// File: rtl/rst_hub.sv
`timescale 1ns/1ps
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD_CYC = 16
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       bor_i,
    input  logic       ext_rst_n_i,
    input  logic       swr_i,
    input  logic       wdt_i,
    input  logic       trap_i,
    input  logic       illop_i,
    input  logic       uninitw_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] cause_o,
    output logic       sys_rst_o
);
    logic   pin_req;
    cause_t evt;
    logic   req_any;

    rst_hub_pinfilt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk_i   (clk_i),
        .clr_i   (por_i),
        .pin_n_i (ext_rst_n_i),
        .req_o   (pin_req)
    );

    always_comb begin
        evt            = '0;
        evt[B_POR]     = por_i;
        evt[B_BOR]     = bor_i;
        evt[B_UNINITW] = uninitw_i;
        evt[B_ILLOP]   = illop_i;
        evt[B_WDT]     = wdt_i;
        evt[B_SWR]     = swr_i;
        evt[B_PIN]     = pin_req;
        evt[B_TRAP]    = trap_i;
    end

    assign req_any = |evt;

    rst_hub_stretch #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk_i (clk_i),
        .req_i (req_any),
        .rst_o (sys_rst_o)
    );

    rst_hub_cause u_cause (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .evt_i     (evt),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cause_o   (cause_o)
    );
endmodule

// File: rtl/rst_hub_chk.sv
`timescale 1ns/1ps
module rst_hub_chk
    import rst_hub_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD_CYC = 16
) (
    input logic       clk_i,
    input logic       por_i,
    input logic       bor_i,
    input logic       ext_rst_n_i,
    input logic       swr_i,
    input logic       wdt_i,
    input logic       trap_i,
    input logic       illop_i,
    input logic       uninitw_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] cause_o,
    input logic       sys_rst_o,
    input logic       pin_req
);
    logic        live_q = 1'b0;
    logic [15:0] quiet_q = '0;
    logic [7:0]  low_run_q = '0;
    cause_t      pulse_vec;
    logic        hw_req;

    always_comb begin
        pulse_vec            = '0;
        pulse_vec[B_UNINITW] = uninitw_i;
        pulse_vec[B_ILLOP]   = illop_i;
        pulse_vec[B_WDT]     = wdt_i;
        pulse_vec[B_SWR]     = swr_i;
        pulse_vec[B_TRAP]    = trap_i;
    end

    assign hw_req = bor_i || pin_req || (pulse_vec != '0);

    always_ff @(posedge clk_i) begin
        live_q <= 1'b1;
        if (por_i || hw_req || !sys_rst_o) quiet_q <= '0;
        else                                quiet_q <= quiet_q + 16'd1;
        if (ext_rst_n_i || por_i)           low_run_q <= '0;
        else if (low_run_q != 8'hFF)        low_run_q <= low_run_q + 8'd1;
    end

    p_any_src_rst_r1: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        hw_req |=> sys_rst_o);

    p_hold_len_r2: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        $fell(sys_rst_o) |-> (quiet_q == 16'(HOLD_CYC)));

    p_pin_filter_r3: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        ($rose(cause_o[B_PIN]) && !$past(wr_en_i)) |-> ($past(low_run_q) >= 8'(FILT_LEN)));

    p_por_load_r5: assert property (@(posedge clk_i) disable iff (!live_q)
        por_i |=> (sys_rst_o && cause_o == POR_VALUE));

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        !wr_en_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

    p_write_lands_r7: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        (wr_en_i && !hw_req) |=> (cause_o == $past(wr_data_i)));

    p_write_no_rst_r7: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        (wr_en_i && !hw_req && !sys_rst_o) |=> !sys_rst_o);

    p_hw_wins_r8: assert property (@(posedge clk_i) disable iff (por_i || !live_q)
        (wr_en_i && pulse_vec != '0) |=> ((cause_o & $past(pulse_vec)) == $past(pulse_vec)));
endmodule

bind rst_hub rst_hub_chk #(.FILT_LEN(FILT_LEN), .HOLD_CYC(HOLD_CYC)) chk_i (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .ext_rst_n_i (ext_rst_n_i),
    .swr_i       (swr_i),
    .wdt_i       (wdt_i),
    .trap_i      (trap_i),
    .illop_i     (illop_i),
    .uninitw_i   (uninitw_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cause_o     (cause_o),
    .sys_rst_o   (sys_rst_o),
    .pin_req     (pin_req)
);

// File: tb/rst_hub_tb_top.sv
`timescale 1ns/1ps
module rst_hub_tb_top;
    localparam int FILT = 4;
    localparam int HOLD = 16;
    localparam int WIN  = 48;

    logic       clk = 1'b0;
    logic       por = 1'b1, bor = 1'b0, pin_n = 1'b1;
    logic       swr = 1'b0, wdt = 1'b0, trap = 1'b0, illop = 1'b0, uninitw = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] cause;
    logic       sys_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rst_hub #(.FILT_LEN(FILT), .HOLD_CYC(HOLD)) dut_i (
        .clk_i(clk), .por_i(por), .bor_i(bor), .ext_rst_n_i(pin_n),
        .swr_i(swr), .wdt_i(wdt), .trap_i(trap), .illop_i(illop),
        .uninitw_i(uninitw), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .cause_o(cause), .sys_rst_o(sys_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cause(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // which: 0..4 pulse sources, 5 brown-out level, 6 pin low run
    task automatic drive(input int which, input int len, output int hi);
        hi = 0;
        for (int k = 0; k < WIN; k++) begin
            swr     = (which == 3) && (k < len);
            wdt     = (which == 2) && (k < len);
            trap    = (which == 4) && (k < len);
            illop   = (which == 1) && (k < len);
            uninitw = (which == 0) && (k < len);
            bor     = (which == 5) && (k < len);
            pin_n   = !((which == 6) && (k < len));
            @(negedge clk);
            if (sys_rst) hi++;
        end
    endtask

    initial begin
        int hi;
        int exp_bit[5];
        exp_bit = '{2, 3, 4, 5, 7};
        repeat (3) @(negedge clk);
        check("R5 reset cause", int'(cause), 8'h03);
        check("R5 reset active", int'(sys_rst), 1);
        por = 1'b0;
        hi = 0;
        for (int k = 0; k < WIN; k++) begin
            if (sys_rst) hi++;
            @(negedge clk);
        end
        check("R2 por release hold", hi, HOLD);

        // R1 R2 R4: each pulse source alone
        for (int s = 0; s < 5; s++) begin
            write_cause(8'h00);
            drive(s, 1, hi);
            check("R1 R2 pulse reset length", hi, 1 + HOLD - 1);
            check("R4 pulse cause bit", int'(cause), 1 << exp_bit[s]);
        end

        // R3: glitch length sweep on the pin
        for (int len = 1; len <= 6; len++) begin
            write_cause(8'h00);
            drive(6, len, hi);
            check("R3 pin reset length", hi, (len >= FILT) ? (len - FILT + 1) + HOLD - 1 : 0);
            check("R3 pin cause bit", int'(cause), (len >= FILT) ? 8'h40 : 8'h00);
        end

        // R6: accumulation, brown-out level
        write_cause(8'h00);
        drive(2, 1, hi);
        drive(4, 1, hi);
        check("R6 two causes kept", int'(cause), 8'h90);
        drive(5, 5, hi);
        check("R2 level reset length", hi, 5 + HOLD - 1);
        check("R6 three causes kept", int'(cause), 8'h92);

        // R7: write sweep, no reset from writes
        for (int v = 0; v < 256; v++) begin
            write_cause(8'(v));
            check("R7 write value", int'(cause), v);
            check("R7 write no reset", int'(sys_rst), 0);
        end

        // R8: hardware set beats write clear
        wr_en = 1'b1; wr_data = 8'h00; illop = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; illop = 1'b0;
        check("R8 hw wins over clear", int'(cause), 8'h08);
        check("R1 reset with write", int'(sys_rst), 1);
        repeat (WIN) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h5A; swr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; swr = 1'b0;
        check("R8 hw bit merged into write", int'(cause), 8'h7A);
        repeat (WIN) @(negedge clk);

        // R5: power-on overrides other events and writes
        write_cause(8'hFC);
        por = 1'b1; wdt = 1'b1; wr_en = 1'b1; wr_data = 8'hF0;
        @(negedge clk);
        wdt = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check("R5 por reload", int'(cause), 8'h03);
        check("R5 por reset", int'(sys_rst), 1);
        por = 1'b0;
        repeat (WIN) @(negedge clk);
        check("R2 released after por", int'(sys_rst), 0);
        check("R6 por bits kept", int'(cause), 8'h03);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule